// File: doc/BRIEF.md
# Packed Lane Shift and Permute Unit

This block rearranges the byte lanes of a packed data word in a single registered step. Each lane is treated as an independent small integer element. The caller supplies a data word, a two-bit operation code and a packed vector of lane indices. One cycle later the block presents the rearranged word together with a valid strobe.

Four operations are available:
- a one-lane move toward the higher lane index, with the vacated lane cleared;
- a one-lane move toward the lower lane index, with the vacated top lane cleared, never sign filled;
- a one-lane rotation toward the higher lane index, where the top lane wraps into lane 0;
- a gather, in which each output lane takes whichever input lane its index names, repeats allowed.

Lane width and lane count are parameters, with defaults of 8 bits and 4 lanes.

Top module: `lane_xbar`

## Requirements
- R1: After reset `out_vld` is 0 and `out_word` is all zeros.
- R2: `out_vld` equals the `in_vld` value of the previous clock edge. `out_word` is loaded only on a cycle where `in_vld` is 1 and holds its value otherwise.
- R3: Opcode 2'b00 (move up): output lane i+1 equals input lane i, and output lane 0 is zero.
- R4: Opcode 2'b01 (move down): output lane i equals input lane i+1, and the top output lane is zero whatever the input's top bit is.
- R5: Opcode 2'b10 (rotate up): output lane i+1 equals input lane i, and output lane 0 equals the input top lane.
- R6: Opcode 2'b11 (gather): output lane j equals the input lane named by index field j. Index field j occupies `in_idx` bits [2j+1:2j], so bits 1:0 steer lane 0 and bits 7:6 steer lane 3.
- R7: In gather, every index value is legal, including repeats, so one input lane may fill several output lanes.
- R8: In gather, the identity index vector (lane3=3, lane2=2, lane1=1, lane0=0, i.e. `in_idx` = 8'hE4) returns the input word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input qualifier |
| in_op | input | 2 | Operation code |
| in_idx | input | 8 | Packed gather indices, 2 bits per output lane |
| in_word | input | 32 | Packed data word |
| out_vld | output | 1 | Result valid, one cycle after `in_vld` |
| out_word | output | 32 | Registered rearranged word |

## Verification
The bench builds the block with its default values: 4 lanes of 8 bits. At that size all 256 index vectors can be swept for the gather against several data words with distinct lane values. This covers every repeat pattern and the identity vector. The three neighbour moves are applied to data words whose lane top bits are both set and clear, so sign fill and wraparound are both exposed. Idle cycles confirm that the output holds and that the strobe follows the input one cycle later.

// File: rtl/lane_xbar_pkg.sv
package lane_xbar_pkg;
   typedef enum logic [1:0] {
      OP_UP   = 2'b00,
      OP_DOWN = 2'b01,
      OP_ROTU = 2'b10,
      OP_GATH = 2'b11
   } lane_op_e;
endpackage

// File: rtl/lane_neighbor.sv
module lane_neighbor #(
   parameter int LW = 8,
   parameter int NL = 4,
   parameter bit WRAP = 1'b0,
   parameter bit UP = 1'b1
) (
   input  logic [LW*NL-1:0] din,
   output logic [LW*NL-1:0] dout
);
   initial begin
      assert (NL >= 2) else $error("lane_neighbor: NL must be at least 2");
      assert (!(WRAP && !UP)) else $error("lane_neighbor: wrap only supported upward");
   end

   generate
      for (genvar i = 0; i < NL; i++) begin : g_lane
         if (UP) begin : g_up
            if (i == 0) begin : g_edge
               if (WRAP) begin : g_wrap
                  assign dout[LW-1:0] = din[LW*NL-1 -: LW];
               end else begin : g_zero
                  assign dout[LW-1:0] = '0;
               end
            end else begin : g_mid
               assign dout[LW*i +: LW] = din[LW*(i-1) +: LW];
            end
         end else begin : g_dn
            if (i == NL-1) begin : g_edge
               assign dout[LW*i +: LW] = '0;
            end else begin : g_mid
               assign dout[LW*i +: LW] = din[LW*(i+1) +: LW];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/lane_gather.sv
module lane_gather #(
   parameter int LW = 8,
   parameter int NL = 4,
   localparam int IW = (NL > 1) ? $clog2(NL) : 1
) (
   input  logic [LW*NL-1:0] din,
   input  logic [IW*NL-1:0] idx,
   output logic [LW*NL-1:0] dout
);
   initial begin
      assert ((1 << IW) == NL) else $error("lane_gather: NL must be a power of two");
   end

   generate
      for (genvar j = 0; j < NL; j++) begin : g_out
         logic [IW-1:0] sel;
         logic [LW-1:0] pick;
         assign sel = idx[IW*j +: IW];
         always_comb begin
            pick = '0;
            for (int k = 0; k < NL; k++) begin
               if (sel == IW'(k)) pick = din[LW*k +: LW];
            end
         end
         assign dout[LW*j +: LW] = pick;
      end
   endgenerate
endmodule

// File: rtl/lane_xbar.sv
module lane_xbar
   import lane_xbar_pkg::*;
#(
   parameter int LW = 8,
   parameter int NL = 4,
   localparam int WW = LW*NL,
   localparam int IW = (NL > 1) ? $clog2(NL) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic [1:0]    in_op,
   input  logic [IW*NL-1:0] in_idx,
   input  logic [WW-1:0] in_word,
   output logic          out_vld,
   output logic [WW-1:0] out_word
);
   initial begin
      assert (LW >= 1) else $error("lane_xbar: LW must be positive");
      assert (NL >= 2) else $error("lane_xbar: NL must be at least 2");
   end

   logic [WW-1:0] w_up, w_dn, w_rot, w_gat, w_sel;

   lane_neighbor #(.LW(LW), .NL(NL), .WRAP(1'b0), .UP(1'b1)) u_up
      (.din(in_word), .dout(w_up));
   lane_neighbor #(.LW(LW), .NL(NL), .WRAP(1'b0), .UP(1'b0)) u_dn
      (.din(in_word), .dout(w_dn));
   lane_neighbor #(.LW(LW), .NL(NL), .WRAP(1'b1), .UP(1'b1)) u_rot
      (.din(in_word), .dout(w_rot));
   lane_gather #(.LW(LW), .NL(NL)) u_gat
      (.din(in_word), .idx(in_idx), .dout(w_gat));

   always_comb begin
      unique case (lane_op_e'(in_op))
         OP_UP:   w_sel = w_up;
         OP_DOWN: w_sel = w_dn;
         OP_ROTU: w_sel = w_rot;
         default: w_sel = w_gat;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_word <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) out_word <= w_sel;
      end
   end

   // R2: strobe follows input by one cycle
   a_r2_vld_follow: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);
   // R2: idle cycles hold the result
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> $stable(out_word));
   // R3: lane 0 cleared after an up move
   a_r3_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_op == 2'b00) |=> (out_word[LW-1:0] == '0));
   // R4: top lane cleared after a down move
   a_r4_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_op == 2'b01) |=> (out_word[WW-1 -: LW] == '0));
   // R5: rotation keeps the lane population
   a_r5_rot_count: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_op == 2'b10) |=> ($countones(out_word) == $countones($past(in_word))));
   // R5: wrapped lane comes from the old top lane
   a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_op == 2'b10) |=> (out_word[LW-1:0] == $past(in_word[WW-1 -: LW])));
   // R1: output valid low during reset
   a_r1_reset: assert property (@(posedge clk)
      !rst_n |=> !out_vld);
endmodule

// File: tb/lane_xbar_test.sv
module lane_xbar_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_vld = 1'b0;
   logic [1:0] in_op = 2'b00;
   logic [7:0] in_idx = 8'h00;
   logic [31:0] in_word = 32'h0;
   logic out_vld;
   logic [31:0] out_word;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lane_xbar uut (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
      .in_idx(in_idx), .in_word(in_word), .out_vld(out_vld), .out_word(out_word));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model(input logic [1:0] op, input logic [7:0] ix,
                                         input logic [31:0] w);
      logic [31:0] r;
      case (op)
         2'b00: r = w << 8;
         2'b01: r = w >> 8;
         2'b10: r = {w[23:0], w[31:24]};
         default: for (int j = 0; j < 4; j++) r[8*j +: 8] = w[8*ix[2*j +: 2] +: 8];
      endcase
      return r;
   endfunction

   // apply one operation, sample after the capturing edge
   task automatic run(input string req, input logic [1:0] op, input logic [7:0] ix,
                      input logic [31:0] w);
      @(negedge clk);
      in_vld = 1'b1; in_op = op; in_idx = ix; in_word = w;
      @(negedge clk);
      in_vld = 1'b0;
      check(req, {31'b0, out_vld}, 32'h1);
      check(req, out_word, model(op, ix, w));
   endtask

   initial begin
      automatic logic [31:0] words[4] = '{32'h8A7B_C4D2, 32'h0102_0304,
                                         32'hFF00_80F1, 32'h7F6E_5D4C};
      repeat (3) @(negedge clk);
      check("R1", {31'b0, out_vld}, 32'h0);
      check("R1", out_word, 32'h0);
      rst_n = 1'b1;
      foreach (words[i]) begin
         run("R3", 2'b00, 8'h00, words[i]);
         check("R3", out_word[7:0], 8'h00);
         run("R4", 2'b01, 8'h00, words[i]);
         check("R4", out_word[31:24], 8'h00);
         run("R5", 2'b10, 8'h00, words[i]);
         check("R5", out_word[7:0], words[i][31:24]);
      end
      for (int w = 0; w < 2; w++)
         for (int ix = 0; ix < 256; ix++)
            run((ix[1:0] == ix[3:2]) ? "R7" : "R6", 2'b11, ix[7:0], words[w]);
      foreach (words[i]) begin
         run("R8", 2'b11, 8'hE4, words[i]);
         check("R8", out_word, words[i]);
      end
      run("R7", 2'b11, 8'hFF, 32'h11_22_33_44);
      check("R7", out_word, 32'h1111_1111);
      // R2: idle cycle: strobe drops, word held
      @(negedge clk);
      in_word = 32'hDEAD_BEEF;
      @(negedge clk);
      check("R2", {31'b0, out_vld}, 32'h0);
      check("R2", out_word, 32'h1111_1111);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule